// File: doc/BRIEF.md
# Two-Way Set-Associative Cache

This block is a small read/write cache that sits between a processor request port and a slower backing memory. A word address is split into a tag, a set index and a word offset within a four-word block. The set index is the block number modulo the number of sets. Both ways of the selected set are compared against the tag in the same cycle, with one comparator per way. A read that hits returns its word one cycle after it is accepted.

On a read miss the block is fetched from memory one word at a time, lowest offset first, over a request/valid handshake. The words go into a victim way, and the requested word is then returned. The victim is an invalid way when one exists, with way 0 taken when both ways are invalid. When both ways are valid, the victim is the least recently used way, tracked by one bit per set. Writes are write-through and no-write-allocate. The requester sees `ready_o` low for as long as a miss or a memory write is in progress.

Top module: `cache2w_top`

## Requirements
- R1: After reset every line is invalid and every LRU bit is clear. `ready_o` is high, and `mem_req_o` and `resp_valid_o` are low. The first read to any address misses.
- R2: Word address bits [1:0] are the word offset, bits [5:2] the set index (block number mod 16) and bits [11:6] the tag. Refill addresses keep the request's tag and set.
- R3: A read hit asserts `resp_valid_o` with the cached word in the cycle after acceptance. It issues no memory request, and `ready_o` stays high.
- R4: A read miss issues exactly four memory reads, at offsets 0, 1, 2, 3 of the block in that order. It then responds with the requested word.
- R5: From the cycle after a miss or a write is accepted until its response, `ready_o` is low. `resp_valid_o` is never high while `ready_o` is low.
- R6: A refill goes into an invalid way of the set if there is one. Way 0 is chosen when both ways are invalid.
- R7: When both ways are valid, a refill evicts the least recently used way. Read hits, write hits and refills all count as uses.
- R8: A write hit updates the cached word and issues one memory write with the request's address and data. Later reads hit and return the new word.
- R9: A write miss issues one memory write only. It allocates no line and leaves the LRU state unchanged.
- R10: While `mem_req_o` is high and `mem_valid_i` is low, the memory address and direction hold stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present, accepted when `ready_o` is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Cache can accept a request (low while stalled) |
| resp_valid_o | output | 1 | Response for the last accepted request |
| resp_rdata_o | output | DATA_W | Read data (zero for writes) |
| mem_req_o | output | 1 | Memory beat requested |
| mem_write_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_valid_i | input | 1 | Memory beat completes (read data valid or write taken) |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
A read hit is due exactly one cycle after the accepting edge. The bench samples on the falling edge right after acceptance and requires the response there, with no memory beat. A miss or write has no fixed latency, because it depends on the memory model's wait. For these the bench samples every falling edge until the response, requiring `ready_o` low on each one. It also logs each memory beat on the falling edge where the model raises `mem_valid_i`. Hit or miss and the victim way are predicted by a bench model of tags, valid bits and LRU bits. The prediction is compared against whether memory traffic was seen.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFILL,
    ST_FILL,
    ST_RESP,
    ST_WRITE
  } ctrl_state_e;
endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
  parameter int SETS  = 16,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             fill_en_i,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_way_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  output logic             hit_o,
  output logic             hit_way_o,
  output logic             victim_o
);
  import cache2w_pkg::*;

  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] way_valid;
  logic [SETS-1:0] lru_q;  // bit = way to evict next

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic             sel;

    assign sel = fill_en_i && (upd_way_i == w[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q <= '0;
      else if (sel) valid_q[upd_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[upd_idx_i] <= fill_tag_i;
    end

    assign way_valid[w] = valid_q[lk_idx_i];
    assign way_hit[w]   = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  end

  assign hit_o     = |way_hit;
  assign hit_way_o = way_hit[1];

  always_comb begin
    if (!way_valid[0])      victim_o = 1'b0;
    else if (!way_valid[1]) victim_o = 1'b1;
    else                    victim_o = lru_q[lk_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lru_q <= '0;
    else if (fill_en_i || touch_en_i) lru_q[upd_idx_i] <= ~upd_way_i;
  end
endmodule

// File: rtl/cache2w_data.sv
module cache2w_data #(
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W      = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(BLOCK_WORDS),
  localparam int AW    = 1 + IDX_W + OFF_W,
  localparam int DEPTH = 2 * SETS * BLOCK_WORDS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words_q [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  assign wr_ptr  = {wr_way_i, wr_idx_i, wr_off_i};
  assign rd_ptr  = {rd_way_i, rd_idx_i, rd_off_i};
  assign rdata_o = words_q[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (we_i) words_q[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(BLOCK_WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              hit_i,
  input  logic              hit_way_i,
  input  logic              victim_i,
  output logic              fill_en_o,
  output logic              touch_en_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic              upd_way_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic              dwe_o,
  output logic              dway_o,
  output logic [IDX_W-1:0]  didx_o,
  output logic [OFF_W-1:0]  doff_o,
  output logic [DATA_W-1:0] dwdata_o,
  output logic              rway_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic [OFF_W-1:0]  roff_o,
  input  logic [DATA_W-1:0] rdata_i
);
  import cache2w_pkg::*;

  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_wdata_q;
  logic              victim_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              resp_valid_q;
  logic [DATA_W-1:0] resp_rdata_q;

  logic [OFF_W-1:0] req_off, cap_off;
  logic [IDX_W-1:0] req_idx, cap_idx;
  logic [TAG_W-1:0] cap_tag;
  logic             accept, refill_beat;

  assign req_off = req_addr_i[OFF_W-1:0];
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign cap_off = cap_addr_q[OFF_W-1:0];
  assign cap_idx = cap_addr_q[OFF_W +: IDX_W];
  assign cap_tag = cap_addr_q[ADDR_W-1 -: TAG_W];

  assign ready_o     = (state_q == ST_IDLE);
  assign accept      = ready_o && req_valid_i;
  assign refill_beat = (state_q == ST_REFILL) && mem_valid_i;

  // tag/LRU update port
  assign fill_en_o  = (state_q == ST_FILL);
  assign touch_en_o = accept && hit_i;
  assign upd_idx_o  = fill_en_o ? cap_idx : req_idx;
  assign upd_way_o  = fill_en_o ? victim_q : hit_way_i;
  assign fill_tag_o = cap_tag;

  // data write port: write hit or refill beat
  always_comb begin
    dwe_o    = 1'b0;
    dway_o   = hit_way_i;
    didx_o   = req_idx;
    doff_o   = req_off;
    dwdata_o = req_wdata_i;
    if (refill_beat) begin
      dwe_o    = 1'b1;
      dway_o   = victim_q;
      didx_o   = cap_idx;
      doff_o   = cnt_q;
      dwdata_o = mem_rdata_i;
    end else if (accept && req_write_i && hit_i) begin
      dwe_o = 1'b1;
    end
  end

  // data read port: lookup in idle, captured request otherwise
  assign rway_o = ready_o ? hit_way_i : victim_q;
  assign ridx_o = ready_o ? req_idx : cap_idx;
  assign roff_o = ready_o ? req_off : cap_off;

  assign mem_req_o   = (state_q == ST_REFILL) || (state_q == ST_WRITE);
  assign mem_write_o = (state_q == ST_WRITE);
  assign mem_addr_o  = mem_write_o ? cap_addr_q : {cap_tag, cap_idx, cnt_q};
  assign mem_wdata_o = cap_wdata_q;

  assign resp_valid_o = resp_valid_q;
  assign resp_rdata_o = resp_rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cap_addr_q   <= '0;
      cap_wdata_q  <= '0;
      victim_q     <= 1'b0;
      cnt_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cap_addr_q  <= req_addr_i;
            cap_wdata_q <= req_wdata_i;
            if (req_write_i) begin
              state_q <= ST_WRITE;
            end else if (hit_i) begin
              resp_valid_q <= 1'b1;
              resp_rdata_q <= rdata_i;
            end else begin
              victim_q <= victim_i;
              cnt_q    <= '0;
              state_q  <= ST_REFILL;
            end
          end
        end
        ST_REFILL: begin
          if (mem_valid_i) begin
            if (cnt_q == OFF_W'(BLOCK_WORDS - 1)) state_q <= ST_FILL;
            else                                 cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_FILL: state_q <= ST_RESP;
        ST_RESP: begin
          resp_valid_q <= 1'b1;
          resp_rdata_q <= rdata_i;
          state_q      <= ST_IDLE;
        end
        ST_WRITE: begin
          if (mem_valid_i) begin
            resp_valid_q <= 1'b1;
            resp_rdata_q <= '0;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SETS        = 16,
  parameter int BLOCK_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(BLOCK_WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic              hit, hit_way, victim;
  logic              fill_en, touch_en, upd_way;
  logic [IDX_W-1:0]  upd_idx;
  logic [TAG_W-1:0]  fill_tag;
  logic              dwe, dway, rway;
  logic [IDX_W-1:0]  didx, ridx;
  logic [OFF_W-1:0]  doff, roff;
  logic [DATA_W-1:0] dwdata, rdata;

  cache2w_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_idx_i   (req_addr_i[OFF_W +: IDX_W]),
    .lk_tag_i   (req_addr_i[ADDR_W-1 -: TAG_W]),
    .fill_en_i  (fill_en),
    .touch_en_i (touch_en),
    .upd_idx_i  (upd_idx),
    .upd_way_i  (upd_way),
    .fill_tag_i (fill_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .victim_o   (victim)
  );

  cache2w_data #(.SETS(SETS), .BLOCK_WORDS(BLOCK_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .we_i     (dwe),
    .wr_way_i (dway),
    .wr_idx_i (didx),
    .wr_off_i (doff),
    .wdata_i  (dwdata),
    .rd_way_i (rway),
    .rd_idx_i (ridx),
    .rd_off_i (roff),
    .rdata_o  (rdata)
  );

  cache2w_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .BLOCK_WORDS(BLOCK_WORDS)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .ready_o      (ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_rdata_o (resp_rdata_o),
    .mem_req_o    (mem_req_o),
    .mem_write_o  (mem_write_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_valid_i  (mem_valid_i),
    .mem_rdata_i  (mem_rdata_i),
    .hit_i        (hit),
    .hit_way_i    (hit_way),
    .victim_i     (victim),
    .fill_en_o    (fill_en),
    .touch_en_o   (touch_en),
    .upd_idx_o    (upd_idx),
    .upd_way_o    (upd_way),
    .fill_tag_o   (fill_tag),
    .dwe_o        (dwe),
    .dway_o       (dway),
    .didx_o       (didx),
    .doff_o       (doff),
    .dwdata_o     (dwdata),
    .rway_o       (rway),
    .ridx_o       (ridx),
    .roff_o       (roff),
    .rdata_i      (rdata)
  );
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W      = 12,
  parameter int BLOCK_WORDS = 4,
  localparam int OFF_W = $clog2(BLOCK_WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              resp_valid_o,
  input logic              mem_req_o,
  input logic              mem_write_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i
);
  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_write_o)));

  // R5
  stall_on_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  // R5
  resp_only_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ready_o);

  // R4
  refill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_write_o && mem_valid_i && (mem_addr_o[OFF_W-1:0] != '1)) |=>
      (mem_req_o && !mem_write_o && (mem_addr_o == $past(mem_addr_o) + 1'b1)));

  // R4
  refill_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_req_o) && !mem_write_o) |-> (mem_addr_o[OFF_W-1:0] == '0));

  // R8
  write_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_write_o && mem_valid_i) |=> (resp_valid_o && !mem_req_o));
endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W), .BLOCK_WORDS(BLOCK_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .resp_valid_o (resp_valid_o),
  .mem_req_o    (mem_req_o),
  .mem_write_o  (mem_write_o),
  .mem_addr_o   (mem_addr_o),
  .mem_valid_i  (mem_valid_i)
);

// File: tb/cache2w_top_bench.sv
module cache2w_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int MEM_WORDS  = 1 << ADDR_W;
  localparam int MEM_LAT    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              ready, resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic              mem_req, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_valid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] slave_mem [MEM_WORDS];
  logic [DATA_W-1:0] exp_mem [MEM_WORDS];
  int                wait_cnt = 0;
  int                beat_n = 0;
  logic [ADDR_W-1:0] beat_addr [8];
  bit                beat_wr [8];
  logic [DATA_W-1:0] beat_wd [8];

  // bench cache model
  bit   mval [16][2];
  int   mtag [16][2];
  bit   mlru [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w_top u_cache2w_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_write_i  (req_write),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .ready_o      (ready),
    .resp_valid_o (resp_valid),
    .resp_rdata_o (resp_rdata),
    .mem_req_o    (mem_req),
    .mem_write_o  (mem_write),
    .mem_addr_o   (mem_addr),
    .mem_wdata_o  (mem_wdata),
    .mem_valid_i  (mem_valid),
    .mem_rdata_i  (mem_rdata)
  );

  function automatic logic [DATA_W-1:0] init_word(int a);
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  function automatic int mk_addr(int tag, int set, int off);
    return (tag << 6) | (set << 2) | off;
  endfunction

  // backing memory: one beat per request after MEM_LAT falling edges
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      wait_cnt++;
      if (wait_cnt >= MEM_LAT) begin
        mem_valid = 1'b1;
        if (mem_write) slave_mem[mem_addr] = mem_wdata;
        else           mem_rdata = slave_mem[mem_addr];
        if (beat_n < 8) begin
          beat_addr[beat_n] = mem_addr;
          beat_wr[beat_n]   = mem_write;
          beat_wd[beat_n]   = mem_wdata;
        end
        beat_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input int addr, input logic [DATA_W-1:0] wd,
                        input string lbl);
    int  s, t, base, cyc, pway;
    bit  phit, stall_bad, obs_hit;
    s = (addr >> 2) & 15;
    t = addr >> 6;
    base = addr & ~3;
    phit = 1'b0;
    pway = 0;
    for (int w = 0; w < 2; w++)
      if (mval[s][w] && mtag[s][w] == t) begin phit = 1'b1; pway = w; end

    @(negedge clk);
    beat_n    = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(addr);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    stall_bad = 1'b0;
    while (!resp_valid && cyc < 300) begin
      if (ready) stall_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    chk(resp_valid, lbl, "response seen", resp_valid, 1);
    chk(ready, "R5", "ready high at response", ready, 1);

    if (!wr) begin
      obs_hit = (beat_n == 0);
      chk(obs_hit == phit, lbl, "hit/miss outcome", obs_hit, phit);
      chk(resp_rdata == exp_mem[addr], lbl, "read data", resp_rdata, exp_mem[addr]);
      if (phit) begin
        chk(cyc == 1, "R3", "hit latency", cyc, 1);
        mlru[s] = ~pway[0];
      end else begin
        chk(beat_n == 4, "R4", "refill beat count", beat_n, 4);
        for (int i = 0; i < 4 && i < beat_n; i++) begin
          chk(beat_addr[i] == ADDR_W'(base + i) && !beat_wr[i], "R2",
              "refill beat address", beat_addr[i], base + i);
        end
        chk(!stall_bad, "R5", "ready low during miss", stall_bad, 0);
        begin
          int v;
          if (!mval[s][0])      v = 0;
          else if (!mval[s][1]) v = 1;
          else                  v = mlru[s] ? 1 : 0;
          mval[s][v] = 1'b1;
          mtag[s][v] = t;
          mlru[s]    = (v == 0);
        end
      end
    end else begin
      chk(beat_n == 1 && beat_wr[0] && beat_addr[0] == ADDR_W'(addr) && beat_wd[0] == wd,
          phit ? "R8" : "R9", "single write beat", beat_wd[0], wd);
      chk(!stall_bad, "R5", "ready low during write", stall_bad, 0);
      chk(resp_rdata == '0, lbl, "write response data", resp_rdata, 0);
      exp_mem[addr] = wd;
      if (phit) mlru[s] = ~pway[0];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, c, d;
    void'($urandom(32'd4711));
    for (int i = 0; i < MEM_WORDS; i++) begin
      slave_mem[i] = init_word(i);
      exp_mem[i]   = init_word(i);
    end
    for (int i = 0; i < 16; i++) begin
      mval[i][0] = 0; mval[i][1] = 0; mlru[i] = 0; mtag[i][0] = 0; mtag[i][1] = 0;
    end
    repeat (3) @(negedge clk);
    chk(ready && !mem_req && !resp_valid, "R1", "reset outputs",
        {ready, mem_req, resp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !mem_req && !resp_valid, "R1", "outputs after reset release",
        {ready, mem_req, resp_valid}, 3'b100);

    a = mk_addr(1, 3, 0);
    b = mk_addr(2, 3, 1);
    c = mk_addr(3, 3, 2);
    d = mk_addr(5, 3, 0);
    do_req(0, a, 0, "R1");            // cold miss, fills way 0 (R6)
    do_req(0, a + 3, 0, "R3");        // hit, other word of block
    do_req(0, mk_addr(1, 4, 1), 0, "R2");  // same tag, next set: miss
    do_req(0, b, 0, "R6");            // fills free way 1
    do_req(0, a, 0, "R3");            // hit way 0, LRU -> way 1
    do_req(0, c, 0, "R7");            // evicts b
    do_req(0, a, 0, "R7");            // a survived
    do_req(0, b, 0, "R7");            // b was evicted: miss, evicts c
    do_req(1, a + 1, 32'hCAFE0001, "R8");  // write hit
    do_req(0, a + 1, 0, "R8");        // hit returns new word
    do_req(1, d, 32'h0D0D0D0D, "R9"); // write miss, no allocate
    do_req(0, d, 0, "R9");            // still a miss
    do_req(0, c, 0, "R7");

    for (int n = 0; n < 400; n++) begin
      int t  = $urandom_range(0, 3);
      int st = $urandom_range(0, 3);
      int of = $urandom_range(0, 3);
      bit w  = ($urandom_range(0, 3) == 0);
      do_req(w, mk_addr(t, st, of), $urandom(), w ? "R8" : "R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule